// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Fetch Redirect

This block owns the fetch program counter of a five-stage in-order integer pipeline and decides, while a branch sits in the decode stage, where fetch goes next. The decode stage supplies three things: the branch class, the two source operand values and the sign-extended word offset. The block tests the branch condition and forms the target address. It then either lets the counter step by four or redirects it at the end of that same decode cycle.

The instruction fetched behind a branch is handled by one of three policies, chosen with a mode input. In the first, the branch is assumed not taken and the fetched successor is squashed when the branch is taken. In the second, that successor always runs as a delay slot. In the third, a likely-taken variant, it runs only when the branch is taken and is squashed otherwise.

A squash marks the instruction entering the fetch/decode register as a bubble. The downstream pipeline must then drop its register-write and memory-write enables. A stall from the hazard unit freezes everything and holds back any redirect until the stall lifts.

Top module: `branch_redirect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fetch_pc` is 0 and `dec_bubble` is 0.
- R2: In a cycle with no stall and no redirect, `fetch_pc` takes the value of `fetch_pc` plus 4 at the next clock edge. An untaken branch does nothing else to the counter.
- R3: `br_kind` encodes the branch class: 2'b01 means branch when `src_a == src_b`, 2'b10 means branch when `src_a == 0`, and 2'b00 or 2'b11 means no branch. `redirect` is high exactly when a valid branch's condition holds in a non-stalled cycle.
- R4: On `redirect`, `next_pc` equals `dec_pc + 4 + (offset << 2)` and `fetch_pc` takes that value at the next clock edge. Otherwise `next_pc` is `fetch_pc + 4`, or `fetch_pc` itself during a stall.
- R5: With `policy` at 2'b00 or 2'b11 (predict untaken), `squash` is high exactly when `redirect` is high.
- R6: With `policy` at 2'b01 (delayed branch), `squash` is never asserted, so the delay slot always executes.
- R7: With `policy` at 2'b10 (likely), `squash` is high exactly when a valid branch in decode is not taken in a non-stalled cycle. A taken likely branch does not squash.
- R8: `dec_bubble` takes the value of `squash` at each non-stalled clock edge. While `dec_bubble` is high, the branch class in decode is treated as no branch: it causes neither redirect nor squash.
- R9: While `stall` is high, `fetch_en` is low, `redirect` and `squash` are low, and `fetch_pc` and `dec_bubble` hold their values at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Successor policy: 00/11 predict untaken, 01 delayed, 10 likely |
| stall | input | 1 | Freeze request from the hazard unit |
| br_kind | input | 2 | Branch class of the decode instruction |
| src_a | input | AW | First source operand read in decode |
| src_b | input | AW | Second source operand read in decode |
| offset | input | AW | Sign-extended word offset |
| dec_pc | input | AW | Address of the instruction in decode |
| fetch_pc | output | AW | Current fetch address |
| next_pc | output | AW | Address fetch uses after this edge |
| redirect | output | 1 | Branch taken this cycle |
| squash | output | 1 | Turn the instruction now being fetched into a bubble |
| dec_bubble | output | 1 | Instruction in decode is a squashed bubble |
| fetch_en | output | 1 | Fetch and fetch/decode register advance |

## Verification
Two pairs of events can land in the same cycle. The first is a stall arriving together with a taken branch in decode. The bench forces this with directed stalled branches and with random stall pulses, and expects the redirect to be withheld and then to occur once the stall clears. The second is a branch that reaches decode in the cycle after a squash, which the bench sets up with back-to-back taken branches under the predict-untaken policy; the second branch must be ignored. A behavioural model in the bench predicts every output on every cycle for every policy.

// File: rtl/branch_redirect.sv
module branch_redirect #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    policy,
  input  logic          stall,
  input  logic [1:0]    br_kind,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] dec_pc,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] next_pc,
  output logic          redirect,
  output logic          squash,
  output logic          dec_bubble,
  output logic          fetch_en
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic          is_br, cond;
  logic [AW-1:0] target;

  assign is_br    = (br_kind == 2'b01 || br_kind == 2'b10) && !dec_bubble;
  assign cond     = (br_kind == 2'b01) ? (src_a == src_b) : (src_a == '0);
  assign target   = dec_pc + STEP + (offset << 2);
  assign fetch_en = !stall;
  assign redirect = fetch_en && is_br && cond;
  assign next_pc  = stall ? fetch_pc : (redirect ? target : fetch_pc + STEP);

  always_comb begin
    case (policy)
      2'b01:   squash = 1'b0;
      2'b10:   squash = fetch_en && is_br && !cond;
      default: squash = redirect;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pc   <= '0;
      dec_bubble <= 1'b0;
    end else if (fetch_en) begin
      fetch_pc   <= next_pc;
      dec_bubble <= squash;
    end
  end

  a_r9_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && stall) |=> ($stable(fetch_pc) && $stable(dec_bubble)));
  a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!redirect && !squash));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !stall && !redirect) |=> (fetch_pc == $past(fetch_pc) + STEP));
  a_r4_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && redirect) |=> (fetch_pc == $past(dec_pc) + STEP + ($past(offset) << 2)));
  a_r6_delay_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'b01) |-> !squash);
  a_r8_bubble_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && squash) |=> dec_bubble);
  a_r8_bubble_inert: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bubble |-> (!redirect && !squash));
endmodule

// File: tb/branch_redirect_tb.sv
module branch_redirect_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] policy = 0, br_kind = 0;
  logic stall = 0;
  logic [31:0] src_a = 0, src_b = 0, offset = 0, dec_pc = 0;
  logic [31:0] fetch_pc, next_pc;
  logic redirect, squash, dec_bubble, fetch_en;
  int checks = 0, fails = 0;
  logic [31:0] m_pc = 0, seed = 32'h1234_5678;
  logic m_bub = 0, prev_stall = 0, prev_red = 0, first = 1;

  always #10 clk = ~clk;

  branch_redirect #(.AW(32)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] pm, input logic st, input logic [1:0] k,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] off);
    logic isb, cnd, tk, sq;
    logic [31:0] nx;
    policy = pm; stall = st; br_kind = k; src_a = a; src_b = b; offset = off;
    dec_pc = m_pc - 4;
    #1;
    isb = (k == 2'b01 || k == 2'b10) && !m_bub;
    cnd = (k == 2'b01) ? (a == b) : (a == 0);
    tk  = !st && isb && cnd;
    nx  = st ? m_pc : (tk ? dec_pc + 4 + (off << 2) : m_pc + 4);
    sq  = st ? 1'b0 : (pm == 2'b01 ? 1'b0 : (pm == 2'b10 ? (isb && !cnd) : tk));
    chk(first ? "R1 fetch_pc" : prev_stall ? "R9 fetch_pc" : prev_red ? "R4 fetch_pc" : "R2 fetch_pc",
        fetch_pc, m_pc);
    chk(first ? "R1 dec_bubble" : "R8 dec_bubble", {31'b0, dec_bubble}, {31'b0, m_bub});
    chk(st ? "R9 redirect" : "R3 redirect", {31'b0, redirect}, {31'b0, tk});
    chk("R4 next_pc", next_pc, nx);
    chk(st ? "R9 squash" : pm == 2'b01 ? "R6 squash" : pm == 2'b10 ? "R7 squash" : "R5 squash",
        {31'b0, squash}, {31'b0, sq});
    chk("R9 fetch_en", {31'b0, fetch_en}, {31'b0, !st});
    @(posedge clk);
    m_pc = nx;
    if (!st) m_bub = sq;
    prev_stall = st; prev_red = tk; first = 0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset fetch_pc", fetch_pc, 0);
    chk("R1 reset dec_bubble", {31'b0, dec_bubble}, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 5, 6, 3);
    step(0, 0, 1, 7, 7, 3);
    step(0, 0, 2, 0, 9, 32'hFFFF_FFFE);
    step(0, 0, 2, 0, 9, 8);
    step(1, 0, 1, 2, 2, 5);
    step(1, 0, 1, 2, 3, 5);
    step(2, 0, 2, 4, 0, 6);
    step(2, 0, 0, 0, 0, 0);
    step(2, 0, 2, 0, 0, 6);
    step(3, 1, 1, 1, 1, 2);
    step(3, 1, 1, 1, 1, 2);
    step(3, 0, 1, 1, 1, 2);
    step(0, 0, 0, 0, 0, 0);
    step(2, 0, 1, 1, 2, 4);
    step(2, 1, 1, 1, 1, 4);
    step(2, 0, 1, 1, 1, 4);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      seed = seed * 32'd1664525 + 32'd1013904223;
      r = seed;
      step(r[31:30], r[29:27] == 0, r[26:25], {30'b0, r[24:23]}, {30'b0, r[22:21]},
           {{24{r[20]}}, r[20:13]});
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule